// File: doc/BRIEF.md
# Dual-Instruction Fetch Sequencer

This block sequences the program of a single-address machine whose 48-bit memory word holds two 24-bit instructions. It places the program counter on the memory address, captures the returned word into a program register and advances the counter by one word. It then offers the two halves of that word to the execution side in turn, left half first. For each dispatched instruction it also forms an effective address: either the raw variable field, or the variable field added to a selected index register. An index register that is flagged for counting steps up by one each time an instruction uses it.

The execution side answers each dispatch in the same cycle. It can ask for a jump, which reloads the counter, skips any half still pending and records a return point in a jump-address register. It can also ask for a halt, which parks the sequencer until a restart pulse arrives with a new start address. Index registers are loaded through a separate load port. Arithmetic and the other commands are executed elsewhere.

Top module: `dual_fetch_seq`

## Requirements
- R1: After reset the sequencer is halted (`halted`=1), issues no read (`mem_rd`=0), dispatches nothing (`disp_valid`=0) and holds `pc`=0.
- R2: A fetch drives `mem_addr`=`pc` with `mem_rd`=1 for one cycle and captures `mem_rdata` on the following cycle. `pc` then advances by one, so after a run stops `pc` is one past the last word fetched.
- R3: Word bit 0 is its most significant bit. The left instruction is `mem_rdata[47:24]` and is dispatched before the right instruction `mem_rdata[23:0]`, which has `disp_right`=1. Within an instruction, bits [23:8] are the address part, bit [7] is the function flag (`disp_fbit`) and bits [6:0] are the command (`disp_cmd`).
- R4: A jump requested while the left half is dispatched prevents the right half from dispatching. Fetching resumes at `exec_jump_addr`.
- R5: On a jump, the jump-address register records the instruction that follows the jump as {word, half}. A left-half jump records (its own word, right half = 1). A right-half jump records (next word, half = 0). A halt leaves the register unchanged.
- R6: In the address part, bit [15] is the index-select flag S, bits [14:12] are the index register number N and bits [11:0] are the variable field V. With S=1 the effective address is index[N] + V, wrapped modulo 2^15.
- R7: With S=0 the effective address is V, zero-extended, whatever N holds, and no index register changes.
- R8: An index register loaded with its count flag set increments by one (modulo 2^15) after each dispatch that uses it with S=1. An index register loaded with the flag clear keeps its value.
- R9: A halt request stops dispatching and fetching, and halt wins over a jump requested in the same cycle. While halted, a `restart` pulse loads `pc` from `restart_addr` and begins fetching. A `restart` pulse while the sequencer is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 15 | Word address of the read |
| mem_rdata | input | 48 | Read data, valid the cycle after `mem_rd` |
| disp_valid | output | 1 | An instruction is being dispatched |
| disp_right | output | 1 | Dispatched instruction is the right half |
| disp_fbit | output | 1 | Function flag of the dispatched instruction |
| disp_cmd | output | 7 | Command of the dispatched instruction |
| disp_ea | output | 15 | Effective address of the dispatched instruction |
| exec_jump | input | 1 | Execution side requests a jump this dispatch |
| exec_jump_addr | input | 15 | Jump target word address |
| exec_halt | input | 1 | Execution side requests a halt this dispatch |
| restart | input | 1 | Restart pulse, honoured only while halted |
| restart_addr | input | 15 | Start word address used by `restart` |
| idx_ld | input | 1 | Load an index register |
| idx_ld_sel | input | 3 | Index register to load |
| idx_ld_val | input | 15 | Value to load |
| idx_ld_count | input | 1 | Count flag to load with the value |
| pc | output | 15 | Program counter |
| jar_addr | output | 15 | Jump-address register, word part |
| jar_right | output | 1 | Jump-address register, half part |
| halted | output | 1 | Sequencer is parked |

## Verification
The bench runs small programs and goes after the places where a sequencer typically slips. A left-half jump must drop the right half; a design that ignored this would emit an extra dispatch. A counting index register is pushed past 2^15 - 1; a design that carried into a sixteenth bit would produce an effective address of 0x8002 instead of 2. The return point is checked for both halves; an off-by-one there would point at the jump itself or at the wrong word. An index-numbered instruction with S clear is checked, as are a non-counting register and a restart pulse sent mid-run; getting these wrong would alter addresses or restart the run.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    localparam int INSTR_W     = 24;
    localparam int ADDR_PART_W = 16;
    localparam int CMD_W       = 7;
    localparam int WORD_W      = 2 * INSTR_W;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH,
        ST_LOAD,
        ST_LEFT,
        ST_RIGHT
    } seq_state_e;

    // one instruction, most significant bit is instruction bit 0
    typedef struct packed {
        logic [ADDR_PART_W-1:0] apart;
        logic                   fbit;
        logic [CMD_W-1:0]       cmd;
    } instr_t;

endpackage

// File: rtl/dfs_decode.sv
module dfs_decode
    import dfs_pkg::*;
#(
    parameter int N_W = 3,
    localparam int V_W = ADDR_PART_W - 1 - N_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              right_i,
    output logic              sel_o,
    output logic [N_W-1:0]    nreg_o,
    output logic [V_W-1:0]    v_o,
    output logic              fbit_o,
    output logic [CMD_W-1:0]  cmd_o
);
    instr_t half;

    always_comb begin
        // left half occupies the upper (earlier numbered) bits
        half   = right_i ? instr_t'(word_i[INSTR_W-1:0])
                         : instr_t'(word_i[WORD_W-1:INSTR_W]);
        sel_o  = half.apart[ADDR_PART_W-1];
        nreg_o = half.apart[ADDR_PART_W-2 -: N_W];
        v_o    = half.apart[V_W-1:0];
        fbit_o = half.fbit;
        cmd_o  = half.cmd;
    end
endmodule

// File: rtl/dfs_index_file.sv
module dfs_index_file #(
    parameter int NUM_IDX = 8,
    parameter int ADDR_W  = 15,
    parameter int V_W     = 12,
    localparam int N_W    = $clog2(NUM_IDX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_i,
    input  logic              sel_i,
    input  logic [N_W-1:0]    nreg_i,
    input  logic [V_W-1:0]    v_i,
    input  logic              ld_i,
    input  logic [N_W-1:0]    ld_sel_i,
    input  logic [ADDR_W-1:0] ld_val_i,
    input  logic              ld_cnt_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic [NUM_IDX-1:0][ADDR_W-1:0] val;
        logic [NUM_IDX-1:0]             cnt;
    } idx_t;

    idx_t q, d;
    logic [ADDR_W-1:0] v_ext;

    always_comb begin
        d     = q;
        v_ext = {{(ADDR_W-V_W){1'b0}}, v_i};
        ea_o  = sel_i ? (q.val[nreg_i] + v_ext) : v_ext;
        if (use_i && sel_i && q.cnt[nreg_i]) begin
            d.val[nreg_i] = q.val[nreg_i] + ONE;
        end
        // an explicit load overrides a post-increment of the same register
        if (ld_i) begin
            d.val[ld_sel_i] = ld_val_i;
            d.cnt[ld_sel_i] = ld_cnt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a counting register used with S set steps by one
    a_r8_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && sel_i && q.cnt[nreg_i] && !ld_i)
        |=> q.val[$past(nreg_i)] == $past(q.val[nreg_i]) + ONE);

    // R7: S clear and no load leaves every index register untouched
    a_r7_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && !ld_i) |=> $stable(q.val));
endmodule

// File: rtl/dfs_seq_ctrl.sv
module dfs_seq_ctrl
    import dfs_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              jump_i,
    input  logic [ADDR_W-1:0] jump_addr_i,
    input  logic              halt_i,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] restart_addr_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] pr_o,
    output logic              disp_valid_o,
    output logic              disp_right_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] jar_addr_o,
    output logic              jar_right_o,
    output logic              halted_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] pr;
        logic [ADDR_W-1:0] jar;
        logic              jar_r;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d            = q;
        mem_rd_o     = 1'b0;
        disp_valid_o = 1'b0;
        disp_right_o = 1'b0;
        unique case (q.st)
            ST_HALT: begin
                if (restart_i) begin
                    d.pc = restart_addr_i;
                    d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_rd_o = 1'b1;
                d.st     = ST_LOAD;
            end
            ST_LOAD: begin
                d.pr = mem_rdata_i;
                d.pc = q.pc + ONE;
                d.st = ST_LEFT;
            end
            ST_LEFT: begin
                disp_valid_o = 1'b1;
                if (halt_i) begin
                    d.st = ST_HALT;
                end else if (jump_i) begin
                    d.jar   = q.pc - ONE;   // word of the skipped right half
                    d.jar_r = 1'b1;
                    d.pc    = jump_addr_i;
                    d.st    = ST_FETCH;
                end else begin
                    d.st = ST_RIGHT;
                end
            end
            ST_RIGHT: begin
                disp_valid_o = 1'b1;
                disp_right_o = 1'b1;
                if (halt_i) begin
                    d.st = ST_HALT;
                end else begin
                    if (jump_i) begin
                        d.jar   = q.pc;
                        d.jar_r = 1'b0;
                        d.pc    = jump_addr_i;
                    end
                    d.st = ST_FETCH;
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HALT;
        end else begin
            q <= d;
        end
    end

    assign mem_addr_o  = q.pc;
    assign pr_o        = q.pr;
    assign pc_o        = q.pc;
    assign jar_addr_o  = q.jar;
    assign jar_right_o = q.jar_r;
    assign halted_o    = (q.st == ST_HALT);

    // R3: the right half is only ever reached from the left half
    a_r3_right_after_left: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RIGHT) |-> $past(q.st == ST_LEFT));

    // R2: capturing a word advances the counter by exactly one
    a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LOAD) |=> (q.pc == $past(q.pc) + ONE));

    // R4: a left-half jump goes straight to a new fetch
    a_r4_skip_right: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LEFT && jump_i && !halt_i) |=> (q.st == ST_FETCH));

    // R9: parked without restart stays parked and keeps its counter
    a_r9_park_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HALT && !restart_i) |=> (q.st == ST_HALT && $stable(q.pc)));

    // R9: halt has priority over a jump in the same dispatch
    a_r9_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && halt_i) |=> (q.st == ST_HALT && $stable(q.pc)));
endmodule

// File: rtl/dual_fetch_seq.sv
module dual_fetch_seq
    import dfs_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int NUM_IDX = 8,
    localparam int N_W    = $clog2(NUM_IDX),
    localparam int V_W    = ADDR_PART_W - 1 - N_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              disp_valid,
    output logic              disp_right,
    output logic              disp_fbit,
    output logic [CMD_W-1:0]  disp_cmd,
    output logic [ADDR_W-1:0] disp_ea,
    input  logic              exec_jump,
    input  logic [ADDR_W-1:0] exec_jump_addr,
    input  logic              exec_halt,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic              idx_ld,
    input  logic [N_W-1:0]    idx_ld_sel,
    input  logic [ADDR_W-1:0] idx_ld_val,
    input  logic              idx_ld_count,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] jar_addr,
    output logic              jar_right,
    output logic              halted
);
    logic [WORD_W-1:0] pr;
    logic              f_sel;
    logic [N_W-1:0]    f_nreg;
    logic [V_W-1:0]    f_v;

    dfs_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_rdata_i    (mem_rdata),
        .jump_i         (exec_jump),
        .jump_addr_i    (exec_jump_addr),
        .halt_i         (exec_halt),
        .restart_i      (restart),
        .restart_addr_i (restart_addr),
        .mem_rd_o       (mem_rd),
        .mem_addr_o     (mem_addr),
        .pr_o           (pr),
        .disp_valid_o   (disp_valid),
        .disp_right_o   (disp_right),
        .pc_o           (pc),
        .jar_addr_o     (jar_addr),
        .jar_right_o    (jar_right),
        .halted_o       (halted)
    );

    dfs_decode #(.N_W(N_W)) u_dec (
        .word_i  (pr),
        .right_i (disp_right),
        .sel_o   (f_sel),
        .nreg_o  (f_nreg),
        .v_o     (f_v),
        .fbit_o  (disp_fbit),
        .cmd_o   (disp_cmd)
    );

    dfs_index_file #(.NUM_IDX(NUM_IDX), .ADDR_W(ADDR_W), .V_W(V_W)) u_idx (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_i    (disp_valid),
        .sel_i    (f_sel),
        .nreg_i   (f_nreg),
        .v_i      (f_v),
        .ld_i     (idx_ld),
        .ld_sel_i (idx_ld_sel),
        .ld_val_i (idx_ld_val),
        .ld_cnt_i (idx_ld_count),
        .ea_o     (disp_ea)
    );

    // R1: a parked sequencer neither reads nor dispatches
    a_r1_quiet_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !disp_valid));
endmodule

// File: tb/tb_dual_fetch_seq.sv
module tb_dual_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd;
    logic [14:0] mem_addr;
    logic [47:0] mem_rdata = '0;
    logic        disp_valid, disp_right, disp_fbit;
    logic [6:0]  disp_cmd;
    logic [14:0] disp_ea;
    logic        exec_jump, exec_halt;
    logic [14:0] exec_jump_addr;
    logic        restart = 1'b0;
    logic [14:0] restart_addr = '0;
    logic        idx_ld = 1'b0;
    logic [2:0]  idx_ld_sel = '0;
    logic [14:0] idx_ld_val = '0;
    logic        idx_ld_count = 1'b0;
    logic [14:0] pc, jar_addr;
    logic        jar_right, halted;

    localparam logic [6:0] C_JMP = 7'h20;
    localparam logic [6:0] C_HLT = 7'h7F;

    always #10 clk = ~clk;   // 50 MHz

    dual_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .disp_valid(disp_valid), .disp_right(disp_right),
        .disp_fbit(disp_fbit), .disp_cmd(disp_cmd), .disp_ea(disp_ea),
        .exec_jump(exec_jump), .exec_jump_addr(exec_jump_addr), .exec_halt(exec_halt),
        .restart(restart), .restart_addr(restart_addr), .idx_ld(idx_ld),
        .idx_ld_sel(idx_ld_sel), .idx_ld_val(idx_ld_val), .idx_ld_count(idx_ld_count),
        .pc(pc), .jar_addr(jar_addr), .jar_right(jar_right), .halted(halted)
    );

    // execution side model: answers in the dispatch cycle
    assign exec_jump      = disp_valid && disp_cmd == C_JMP;
    assign exec_halt      = disp_valid && disp_cmd == C_HLT;
    assign exec_jump_addr = disp_ea;

    // program memory, one cycle read latency
    logic [47:0] mem [0:63];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // instruction: {S, N[2:0], V[11:0], F, CMD[6:0]}
    function automatic logic [23:0] ins(input bit s, input int n, input int v,
                                        input bit f, input logic [6:0] c);
        return {s, 3'(n), 12'(v), f, c};
    endfunction

    // expected dispatch records {right, fbit, cmd[6:0], ea[14:0]}
    localparam int NEXP = 17;
    localparam logic [23:0] EXP [0:NEXP-1] = '{
        // run A from word 10
        {1'b0, 1'b0, 7'h01, 15'd5},      // R3 left first, S clear
        {1'b1, 1'b0, 7'h02, 15'd107},    // R6 idx1 + 7
        {1'b0, 1'b0, 7'h03, 15'h7FFF},   // R6 idx2 + 1
        {1'b1, 1'b0, 7'h03, 15'd2},      // R6 wrap modulo 2^15, R8 counted
        {1'b0, 1'b0, 7'h20, 15'd20},     // R4 left jump, right skipped
        {1'b0, 1'b0, 7'h05, 15'd50},     // R8 idx3 first use
        {1'b1, 1'b0, 7'h20, 15'd61},     // R8 idx3 counted once
        {1'b0, 1'b1, 7'h06, 15'd52},     // R3 function flag
        {1'b1, 1'b0, 7'h7F, 15'd0},      // R9 halt
        // run B from word 30
        {1'b0, 1'b0, 7'h7F, 15'd0},      // R9 left halt skips right
        // run C from word 50
        {1'b0, 1'b0, 7'h01, 15'd100},    // R8 non-counting idx1
        {1'b1, 1'b0, 7'h01, 15'd100},    // R8 still 100
        {1'b0, 1'b0, 7'h0B, 15'h123},    // R7 S clear with N=3
        {1'b1, 1'b0, 7'h0C, 15'd53},     // R7 idx3 untouched by S-clear use
        {1'b0, 1'b0, 7'h7F, 15'd0},
        // run D from word 40
        {1'b0, 1'b0, 7'h20, 15'd45},     // R5 left jump
        {1'b0, 1'b0, 7'h7F, 15'd0}
    };
    localparam int NRUN = 4;
    localparam int RUN_START [0:NRUN-1] = '{10, 30, 50, 40};
    localparam int RUN_LEN   [0:NRUN-1] = '{9, 1, 5, 2};
    localparam int RUN_PC    [0:NRUN-1] = '{62, 31, 53, 46};
    localparam int RUN_JAR   [0:NRUN-1] = '{21, 21, 21, 40};
    localparam int RUN_JARR  [0:NRUN-1] = '{0, 0, 0, 1};

    logic [23:0] got [0:31];
    int          ngot;

    task automatic load_idx(input int sel, input int val, input bit cnt);
        @(negedge clk);
        idx_ld = 1'b1; idx_ld_sel = 3'(sel); idx_ld_val = 15'(val); idx_ld_count = cnt;
        @(negedge clk);
        idx_ld = 1'b0;
    endtask

    task automatic run_prog(input int start, input bit poke_restart);
        ngot = 0;
        @(negedge clk);
        restart = 1'b1; restart_addr = 15'(start);
        @(negedge clk);
        restart = 1'b0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (poke_restart && cyc == 3) begin
                restart = 1'b1; restart_addr = 15'd5;   // R9 ignored while running
            end else begin
                restart = 1'b0;
            end
            if (halted) break;
            if (disp_valid && ngot < 32) begin
                got[ngot] = {disp_right, disp_fbit, disp_cmd, disp_ea};
                ngot++;
            end
            @(negedge clk);
        end
        restart = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[10] = {ins(0,0,5,0,7'h01),     ins(1,1,7,0,7'h02)};
        mem[11] = {ins(1,2,1,0,7'h03),     ins(1,2,3,0,7'h03)};
        mem[12] = {ins(0,0,20,0,C_JMP),    ins(0,0,9,0,7'h04)};
        mem[20] = {ins(1,3,0,0,7'h05),     ins(1,3,10,0,C_JMP)};
        mem[61] = {ins(1,3,0,1,7'h06),     ins(0,0,0,0,C_HLT)};
        mem[30] = {ins(0,0,0,0,C_HLT),     ins(0,0,0,0,7'h09)};
        mem[50] = {ins(1,1,0,0,7'h01),     ins(1,1,0,0,7'h01)};
        mem[51] = {ins(0,3,12'h123,0,7'h0B), ins(1,3,0,0,7'h0C)};
        mem[52] = {ins(0,0,0,0,C_HLT),     ins(0,0,0,0,7'h0E)};
        mem[40] = {ins(0,0,45,0,C_JMP),    ins(0,0,0,0,7'h0A)};
        mem[45] = {ins(0,0,0,0,C_HLT),     ins(0,0,0,0,7'h0D)};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(halted == 1'b1,     "R1 halted", int'(halted), 1);
        check(mem_rd == 1'b0,     "R1 mem_rd", int'(mem_rd), 0);
        check(disp_valid == 1'b0, "R1 disp_valid", int'(disp_valid), 0);
        check(pc == 15'd0,        "R1 pc", int'(pc), 0);

        load_idx(1, 100, 1'b0);
        load_idx(2, 15'h7FFE, 1'b1);
        load_idx(3, 50, 1'b1);

        // R2 fetch handshake: read issued at the restart address
        @(negedge clk);
        restart = 1'b1; restart_addr = 15'd30;
        @(negedge clk);
        restart = 1'b0;
        check(mem_rd == 1'b1 && mem_addr == 15'd30, "R2 fetch address",
              int'(mem_addr), 30);
        for (int cyc = 0; cyc < 20 && !halted; cyc++) @(negedge clk);

        // table walk over the programs
        begin
            int base = 0;
            for (int r = 0; r < NRUN; r++) begin
                run_prog(RUN_START[r], r == 2);
                check(ngot == RUN_LEN[r], "R4/R9 dispatch count", ngot, RUN_LEN[r]);
                for (int k = 0; k < RUN_LEN[r]; k++) begin
                    if (k < ngot)
                        check(got[k] == EXP[base+k], "R3/R6/R7/R8 dispatch record",
                              int'(got[k]), int'(EXP[base+k]));
                end
                base += RUN_LEN[r];
                check(pc == 15'(RUN_PC[r]), "R2 pc after run", int'(pc), RUN_PC[r]);
                check(jar_addr == 15'(RUN_JAR[r]) && jar_right == RUN_JARR[r][0],
                      "R5 jump-address register", int'({jar_addr, jar_right}),
                      (RUN_JAR[r] << 1) | RUN_JARR[r]);
                check(halted == 1'b1, "R9 halted after halt", int'(halted), 1);
            end
        end

        // R9 parked: nothing moves without restart
        repeat (5) @(negedge clk);
        check(halted && pc == 15'd46 && !mem_rd, "R9 parked hold", int'(pc), 46);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule